// File: doc/BRIEF.md
# Four-Phase Handshake Bus Master

This block starts read and write transfers on a bus that has no shared clock. Each transfer is timed only by a request line that the master drives and an acknowledge line that the slave drives. The master runs from its own local clock. It uses that clock to count fixed guard intervals between handshake edges. These intervals absorb skew between bus lines, the slave's address decode time and the setup time of the master's read-data capture.

A transfer begins with a one-cycle start pulse on the request side, carrying address, direction and write data.

1. The master puts address, direction and write data on the bus.
2. After a skew-plus-decode interval it raises its request line.
3. When the synchronized acknowledge arrives, it waits a skew-plus-setup interval, captures read data and drops the request line.
4. One skew interval later it takes address, direction and data off the bus.
5. The transfer completes with a one-cycle done pulse once the acknowledge has also returned low.

If the acknowledge fails to rise, or fails to fall, within a timeout window, the transfer ends with a one-cycle error pulse instead.

Top module: `hsk_bus_master`

## Requirements
- R1: While reset is asserted, bus_drive, bus_mrdy, req_done and req_err are all 0.
- R2: A req_start seen in idle makes bus_drive rise at the next clock edge, with bus_addr, bus_write and bus_wdata equal to the request values (bus_write 1 means write).
- R3: bus_mrdy rises exactly SKEW_CYC + DECODE_CYC cycles after bus_drive rises.
- R4: While bus_drive is high, bus_addr, bus_write and bus_wdata do not change, and a req_start that arrives during a transfer is ignored: no second transfer and no second done.
- R5: bus_mrdy falls exactly SYNC_STAGES + 1 + SKEW_CYC + SETUP_CYC cycles after bus_srdy rises. For a read, req_rdata then holds the bus_rdata value present at that edge.
- R6: bus_drive falls exactly SKEW_CYC cycles after bus_mrdy falls in a completed transfer.
- R7: req_done is a single-cycle pulse, exactly one per completed transfer. It occurs at the later of (bus_drive fall + 1) and (bus_srdy fall + SYNC_STAGES + 1), with bus_drive and bus_mrdy both low.
- R8: If the synchronized bus_srdy is not seen within TIMEOUT_CYC cycles after bus_mrdy rises, then exactly TIMEOUT_CYC cycles after that rise bus_mrdy and bus_drive fall together, req_err pulses for one cycle and no done follows.
- R9: req_done and req_err are never high together, and bus_mrdy is high only while bus_drive is high.
- R10: If bus_srdy stays high after the master has released the bus, req_err pulses exactly TIMEOUT_CYC cycles after bus_drive fell, no done is given, and a following transfer completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that times all guard intervals |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle pulse that requests a transfer; ignored while busy |
| req_write | input | 1 | Direction of the requested transfer, 1 for write |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Data for a write |
| req_done | output | 1 | One-cycle pulse when a four-phase cycle has fully completed |
| req_err | output | 1 | One-cycle pulse when a transfer was aborted by timeout |
| req_rdata | output | DATA_W | Data captured by the latest completed read |
| bus_drive | output | 1 | High while address, direction and write data are presented |
| bus_addr | output | ADDR_W | Address lines, zero when not driven |
| bus_write | output | 1 | Direction line, zero when not driven |
| bus_wdata | output | DATA_W | Write data lines, zero when not driven |
| bus_rdata | input | DATA_W | Read data lines from the slave |
| bus_mrdy | output | 1 | Master request line of the handshake |
| bus_srdy | input | 1 | Slave acknowledge line, asynchronous to clk |

## Verification
The hardest situation to reach from the ports is the release-phase timeout. The slave must answer normally and then keep its acknowledge high after the request line has fallen. The bench does this with a slave model that has a hold-acknowledge mode, and then clears it to show recovery on the next transfer. A mute mode covers the timeout while waiting for the acknowledge. A varying response latency per address moves the acknowledge edge across different phases of the guard counters while all sixteen addresses are written and read back twice.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [2:0] {
      HS_IDLE,
      HS_PRESENT,
      HS_WAIT_ACK,
      HS_SETTLE,
      HS_HOLD,
      HS_WAIT_REL
   } hsk_state_t;

   function automatic int hsk_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hsk_timer.sv
module hsk_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/hsk_xfer_regs.sv
module hsk_xfer_regs #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              write_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              capture,
   input  logic [DATA_W-1:0] rdata_in,
   input  logic              drive,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rdata_out
);
   logic [ADDR_W-1:0] addr_q;
   logic              write_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         write_q <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= addr_in;
         write_q <= write_in;
         wdata_q <= write_in ? wdata_in : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rdata_q <= '0;
      else if (capture && !write_q) rdata_q <= rdata_in;
   end

   assign bus_addr  = drive ? addr_q  : '0;
   assign bus_write = drive & write_q;
   assign bus_wdata = drive ? wdata_q : '0;
   assign rdata_out = rdata_q;
endmodule

// File: rtl/hsk_bus_master.sv
module hsk_bus_master
   import hsk_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SKEW_CYC    = 2,
   parameter int DECODE_CYC  = 1,
   parameter int SETUP_CYC   = 1,
   parameter int TIMEOUT_CYC = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_done,
   output logic              req_err,
   output logic [DATA_W-1:0] req_rdata,
   output logic              bus_drive,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_mrdy,
   input  logic              bus_srdy
);
   localparam int PRE_N = SKEW_CYC + DECODE_CYC;
   localparam int STL_N = SKEW_CYC + SETUP_CYC;
   localparam int MAX_N = hsk_max(hsk_max(PRE_N, STL_N), hsk_max(SKEW_CYC, TIMEOUT_CYC));
   localparam int CW    = $clog2(MAX_N + 1);
   localparam logic [CW-1:0] LD_PRE  = CW'(PRE_N - 1);
   localparam logic [CW-1:0] LD_STL  = CW'(STL_N - 1);
   localparam logic [CW-1:0] LD_SKEW = CW'(SKEW_CYC - 1);
   localparam logic [CW-1:0] LD_TO   = CW'(TIMEOUT_CYC - 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("hsk_bus_master: widths must be at least 1");
      end
      if (SKEW_CYC < 1) begin : g_bad_skew
         $error("hsk_bus_master: SKEW_CYC must be at least 1");
      end
      if (DECODE_CYC < 0 || SETUP_CYC < 0) begin : g_bad_guard
         $error("hsk_bus_master: decode and setup intervals cannot be negative");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("hsk_bus_master: TIMEOUT_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hsk_bus_master: SYNC_STAGES must be at least 2");
      end
   endgenerate

   hsk_state_t st, st_nxt;
   logic srdy_s, tmr_exp, tmr_ld;
   logic [CW-1:0] tmr_val;
   logic accept, capture;
   logic set_mrdy, clr_mrdy, set_drv, clr_drv, pulse_done, pulse_err;
   logic mrdy_q, drv_q, done_q, err_q;

   hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bus_srdy),
      .q_sync  (srdy_s)
   );

   hsk_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   hsk_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .addr_in   (req_addr),
      .write_in  (req_write),
      .wdata_in  (req_wdata),
      .capture   (capture),
      .rdata_in  (bus_rdata),
      .drive     (drv_q),
      .bus_addr  (bus_addr),
      .bus_write (bus_write),
      .bus_wdata (bus_wdata),
      .rdata_out (req_rdata)
   );

   always_comb begin
      st_nxt     = st;
      tmr_ld     = 1'b0;
      tmr_val    = '0;
      accept     = 1'b0;
      capture    = 1'b0;
      set_mrdy   = 1'b0;
      clr_mrdy   = 1'b0;
      set_drv    = 1'b0;
      clr_drv    = 1'b0;
      pulse_done = 1'b0;
      pulse_err  = 1'b0;
      unique case (st)
         HS_IDLE: begin
            if (req_start) begin
               accept  = 1'b1;
               set_drv = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = LD_PRE;
               st_nxt  = HS_PRESENT;
            end
         end
         HS_PRESENT: begin
            if (tmr_exp) begin
               set_mrdy = 1'b1;
               tmr_ld   = 1'b1;
               tmr_val  = LD_TO;
               st_nxt   = HS_WAIT_ACK;
            end
         end
         HS_WAIT_ACK: begin
            if (srdy_s) begin
               tmr_ld  = 1'b1;
               tmr_val = LD_STL;
               st_nxt  = HS_SETTLE;
            end else if (tmr_exp) begin
               clr_mrdy  = 1'b1;
               clr_drv   = 1'b1;
               pulse_err = 1'b1;
               st_nxt    = HS_IDLE;
            end
         end
         HS_SETTLE: begin
            if (tmr_exp) begin
               capture  = 1'b1;
               clr_mrdy = 1'b1;
               tmr_ld   = 1'b1;
               tmr_val  = LD_SKEW;
               st_nxt   = HS_HOLD;
            end
         end
         HS_HOLD: begin
            if (tmr_exp) begin
               clr_drv = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = LD_TO;
               st_nxt  = HS_WAIT_REL;
            end
         end
         HS_WAIT_REL: begin
            if (!srdy_s) begin
               pulse_done = 1'b1;
               st_nxt     = HS_IDLE;
            end else if (tmr_exp) begin
               pulse_err = 1'b1;
               st_nxt    = HS_IDLE;
            end
         end
         default: st_nxt = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= HS_IDLE;
         mrdy_q <= 1'b0;
         drv_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st     <= st_nxt;
         done_q <= pulse_done;
         err_q  <= pulse_err;
         if (set_mrdy)      mrdy_q <= 1'b1;
         else if (clr_mrdy) mrdy_q <= 1'b0;
         if (set_drv)       drv_q  <= 1'b1;
         else if (clr_drv)  drv_q  <= 1'b0;
      end
   end

   assign bus_mrdy  = mrdy_q;
   assign bus_drive = drv_q;
   assign req_done  = done_q;
   assign req_err   = err_q;
endmodule

// File: rtl/hsk_bus_master_chk.sv
module hsk_bus_master_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_drive,
   input logic              bus_mrdy,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_write,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              req_done,
   input logic              req_err
);
   a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_done && req_err));

   a_r9_mrdy_inside_drive: assert property (@(posedge clk) disable iff (!rst_n)
      bus_mrdy |-> bus_drive);

   a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && $past(bus_drive)) |->
      ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> !req_err);

   a_r7_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> (!bus_drive && !bus_mrdy));

   a_r3_mrdy_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_mrdy) |-> $past(bus_drive));

   a_r6_drive_falls_mrdy_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_drive) |-> !bus_mrdy);
endmodule

bind hsk_bus_master hsk_bus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_drive (bus_drive),
   .bus_mrdy  (bus_mrdy),
   .bus_addr  (bus_addr),
   .bus_write (bus_write),
   .bus_wdata (bus_wdata),
   .req_done  (req_done),
   .req_err   (req_err)
);

// File: tb/tb_hsk_bus_master.sv
`timescale 1ns/1ps

module tb_hsk_slave (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mrdy,
   input  logic [3:0] addr,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  int         lat,
   input  logic       mute,
   input  logic       stuck,
   output logic       srdy,
   output logic [7:0] rdata
);
   logic [7:0] mem [16];
   int wcnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srdy  <= 1'b0;
         rdata <= 8'h00;
         wcnt  <= 0;
         for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      end else if (!srdy) begin
         if (mrdy && !mute) begin
            if (wcnt >= lat) begin
               srdy <= 1'b1;
               wcnt <= 0;
               if (wr) mem[addr] <= wdata;
               else    rdata     <= mem[addr];
            end else begin
               wcnt <= wcnt + 1;
            end
         end else begin
            wcnt <= 0;
         end
      end else if (!mrdy && !stuck) begin
         srdy <= 1'b0;
      end
   end
endmodule

module tb_hsk_bus_master;
   localparam int SKEW = 2;
   localparam int DEC  = 1;
   localparam int SET  = 1;
   localparam int TO   = 20;
   localparam int SYN  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0, req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic req_done, req_err, bus_drive, bus_write, bus_mrdy, bus_srdy;
   logic [7:0] req_rdata, bus_wdata, bus_rdata;
   logic [3:0] bus_addr;
   int   slv_lat = 0;
   logic slv_mute = 1'b0, slv_stuck = 1'b0;

   always #2 clk = ~clk;

   hsk_bus_master #(
      .ADDR_W(4), .DATA_W(8), .SKEW_CYC(SKEW), .DECODE_CYC(DEC),
      .SETUP_CYC(SET), .TIMEOUT_CYC(TO), .SYNC_STAGES(SYN)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
      .req_err(req_err), .req_rdata(req_rdata), .bus_drive(bus_drive),
      .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy)
   );

   tb_hsk_slave u_slave (
      .clk(clk), .rst_n(rst_n), .mrdy(bus_mrdy), .addr(bus_addr), .wr(bus_write),
      .wdata(bus_wdata), .lat(slv_lat), .mute(slv_mute), .stuck(slv_stuck),
      .srdy(bus_srdy), .rdata(bus_rdata)
   );

   int n_chk = 0, n_fail = 0;
   int ncount = 0;
   int t_drv_rise = -1000, t_drv_fall = -1000, t_mrdy_rise = -1000, t_mrdy_fall = -1000;
   int t_srdy_rise = -1000, t_srdy_fall = -1000, t_done = -1000, t_err = -1000;
   int done_total = 0, err_total = 0, addr_bad = 0;
   logic [3:0] exp_addr = '0;
   logic [3:0] rise_addr = '0;
   logic rise_wr = 1'b0;
   logic [7:0] rise_wdata = '0;
   logic [7:0] bus_rd_at_fall = '0;
   logic p_drv = 1'b0, p_mrdy = 1'b0, p_srdy = 1'b0;
   logic [7:0] exp_mem [16];

   always @(negedge clk) begin
      ncount = ncount + 1;
      if (bus_drive && !p_drv) begin
         t_drv_rise = ncount; rise_addr = bus_addr; rise_wr = bus_write; rise_wdata = bus_wdata;
      end
      if (!bus_drive && p_drv) t_drv_fall = ncount;
      if (bus_mrdy && !p_mrdy) t_mrdy_rise = ncount;
      if (!bus_mrdy && p_mrdy) begin t_mrdy_fall = ncount; bus_rd_at_fall = bus_rdata; end
      if (bus_srdy && !p_srdy) t_srdy_rise = ncount;
      if (!bus_srdy && p_srdy) t_srdy_fall = ncount;
      if (req_done) begin t_done = ncount; done_total = done_total + 1; end
      if (req_err)  begin t_err = ncount;  err_total = err_total + 1; end
      if (bus_drive && bus_addr != exp_addr) addr_bad = addr_bad + 1;
      p_drv = bus_drive; p_mrdy = bus_mrdy; p_srdy = bus_srdy;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // mode 0: normal, 1: slave mute, 2: slave holds acknowledge
   task automatic do_xfer(input logic wr, input logic [3:0] a, input logic [7:0] d,
                          input int mode, input bit busy_start);
      int t_s, base_done, base_err, base_bad, rise_snap, exp_done;
      bit fin;
      @(negedge clk); #1;
      exp_addr = a; t_s = ncount;
      base_done = done_total; base_err = err_total; base_bad = addr_bad;
      req_addr = a; req_write = wr; req_wdata = d; req_start = 1'b1;
      @(negedge clk); #1;
      req_start = 1'b0;
      if (busy_start) begin
         repeat (3) @(negedge clk);
         #1;
         req_addr = ~a; req_write = ~wr; req_wdata = ~d; req_start = 1'b1;
         @(negedge clk); #1;
         req_start = 1'b0;
      end
      fin = 1'b0;
      for (int i = 0; i < 200 && !fin; i++) begin
         @(negedge clk); #1;
         if (done_total != base_done || err_total != base_err) fin = 1'b1;
      end
      check(fin, "R7/R8 transfer ends", int'(fin), 1);
      check(t_drv_rise == t_s + 1, "R2 drive rises one edge after start", t_drv_rise, t_s + 1);
      check(rise_addr == a, "R2 address on bus", int'(rise_addr), int'(a));
      check(rise_wr == wr, "R2 direction on bus", int'(rise_wr), int'(wr));
      check(rise_wdata == (wr ? d : 8'h00), "R2 write data on bus", int'(rise_wdata), int'(wr ? d : 8'h00));
      check(t_mrdy_rise == t_drv_rise + SKEW + DEC, "R3 mrdy rise delay", t_mrdy_rise, t_drv_rise + SKEW + DEC);
      if (mode == 1) begin
         check(t_err == t_mrdy_rise + TO, "R8 timeout edge", t_err, t_mrdy_rise + TO);
         check(t_mrdy_fall == t_err, "R8 mrdy drops on abort", t_mrdy_fall, t_err);
         check(t_drv_fall == t_err, "R8 drive drops on abort", t_drv_fall, t_err);
         check(done_total == base_done, "R8 no done after abort", done_total - base_done, 0);
      end else begin
         check(t_mrdy_fall == t_srdy_rise + SYN + 1 + SKEW + SET, "R5 mrdy fall delay",
               t_mrdy_fall, t_srdy_rise + SYN + 1 + SKEW + SET);
         check(t_drv_fall == t_mrdy_fall + SKEW, "R6 drive fall delay", t_drv_fall, t_mrdy_fall + SKEW);
         if (!wr) check(req_rdata == bus_rd_at_fall && req_rdata == exp_mem[a], "R5 read data",
                        int'(req_rdata), int'(exp_mem[a]));
         if (mode == 2) begin
            check(t_err == t_drv_fall + TO, "R10 release timeout edge", t_err, t_drv_fall + TO);
            check(done_total == base_done, "R10 no done on release timeout", done_total - base_done, 0);
         end else begin
            exp_done = (t_drv_fall + 1 > t_srdy_fall + SYN + 1) ? t_drv_fall + 1 : t_srdy_fall + SYN + 1;
            check(t_done == exp_done, "R7 done edge", t_done, exp_done);
            check(done_total == base_done + 1, "R7 one done", done_total - base_done, 1);
            check(err_total == base_err, "R9 no error with done", err_total - base_err, 0);
         end
      end
      check(addr_bad == base_bad, "R4 address held while driven", addr_bad - base_bad, 0);
      if (busy_start) begin
         rise_snap = t_drv_rise;
         repeat (8) @(negedge clk);
         #1;
         check(t_drv_rise == rise_snap, "R4 busy start ignored", t_drv_rise, rise_snap);
         check(done_total == base_done + 1, "R4 no extra done", done_total - base_done, 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      #1;
      check(!bus_drive && !bus_mrdy && !req_done && !req_err, "R1 reset outputs",
            int'({bus_drive, bus_mrdy, req_done, req_err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check(!bus_drive && !bus_mrdy, "R1 idle after reset", int'({bus_drive, bus_mrdy}), 0);

      for (int a = 0; a < 16; a++) begin
         slv_lat = a % 4;
         exp_mem[a] = 8'((a * 37 + 11) & 8'hFF);
         do_xfer(1'b1, 4'(a), exp_mem[a], 0, 1'b0);
      end
      for (int a = 0; a < 16; a++) begin
         slv_lat = (a + 1) % 4;
         do_xfer(1'b0, 4'(a), 8'h00, 0, 1'b0);
      end
      for (int a = 0; a < 16; a += 2) begin
         slv_lat = 3 - (a % 4);
         exp_mem[a] = ~exp_mem[a];
         do_xfer(1'b1, 4'(a), exp_mem[a], 0, 1'b0);
      end
      for (int a = 0; a < 16; a++) begin
         slv_lat = a % 3;
         do_xfer(1'b0, 4'(a), 8'h00, 0, 1'b0);
      end

      slv_lat = 2;
      do_xfer(1'b1, 4'd5, 8'h3C, 0, 1'b1);
      exp_mem[5] = 8'h3C;
      do_xfer(1'b0, 4'd5, 8'h00, 0, 1'b1);

      slv_mute = 1'b1;
      do_xfer(1'b0, 4'd9, 8'h00, 1, 1'b0);
      slv_mute = 1'b0;
      do_xfer(1'b0, 4'd9, 8'h00, 0, 1'b0);

      slv_stuck = 1'b1;
      do_xfer(1'b0, 4'd3, 8'h00, 2, 1'b0);
      slv_stuck = 1'b0;
      repeat (4) @(negedge clk);
      do_xfer(1'b1, 4'd3, 8'hA5, 0, 1'b0);
      exp_mem[3] = 8'hA5;
      do_xfer(1'b0, 4'd3, 8'h00, 0, 1'b0);

      report();
   end
endmodule